// File: doc/BRIEF.md
# Parallel Flash Write Controller

This block is a clocked bus master for a byte-wide asynchronous flash. It accepts one request at a time on a valid/ready handshake. A request carries an operation code, an address and a data byte. The block then drives chip-enable, write-enable and output-enable, the address bus and the data bus through the full protected command sequence for that operation. The operation is a byte program, a sector erase or a whole-chip erase.

After the last command write, the block polls the flash. It reads the target location over and over until bit 6 of the returned byte holds the same value on two reads in a row. It then reads the location twice more to confirm the result. One `done_o` pulse reports the outcome, with `ok_o` set on success and `timeout_o` set when the poll budget for the operation runs out.

Every bus cycle has three phases, each a set number of clocks:
- a setup phase with chip-enable low;
- a strobe phase;
- a hold phase.

The address and the write data stay fixed across all three phases.

Top module: `flash_wr_ctrl`

## Requirements
- R1: Operation code 0 (program) issues exactly four writes, as address/data pairs in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data. The bits of an unlock address above bit 14 are zero.
- R2: Operation code 1 (sector erase) issues exactly six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then 30h at the request address.
- R3: Operation code 2 (chip erase) issues the same five leading writes as R2, then 10h at address 5555h.
- R4: In every write cycle:
  - chip-enable is low for SETUP_CYC clocks before write-enable falls;
  - write-enable stays low for exactly PULSE_CYC clocks;
  - output-enable is high and the data bus is driven while write-enable is low;
  - the address and data present at the falling edge of write-enable are unchanged at its rising edge.

  Write-enable and output-enable are never low together, and chip-enable is low whenever either strobe is low.
- R5: No read strobe occurs before the rising edge of write-enable that ends the last write of the sequence.
- R6: Polling reads the request address. Completion is declared on the first poll read whose bit 6 equals bit 6 of the poll read just before it.
- R7: After completion, exactly two verify reads follow. `ok_o` is 1 only if both return the expected byte: the request data for a program, FFh for an erase. Otherwise the request ends with `ok_o`=0 and `timeout_o`=0.
- R8: If PROG_POLLS (program), SECT_POLLS (sector erase) or CHIP_POLLS (chip erase) poll reads pass without completion, the request ends with `timeout_o`=1 and `ok_o`=0. No verify read is made.
- R9: `req_ready_o` is 1 only when idle. A request is taken on a clock edge where valid and ready are both 1. Ready stays 0 from acceptance until `done_o` has pulsed. A request presented while busy has no effect.
- R10: `done_o` is a one-cycle pulse. `ok_o` and `timeout_o` are 0 outside that cycle and are never 1 together.
- R11: Operation code 3 is accepted and ends with `done_o`, `ok_o`=0, `timeout_o`=0 and no bus activity.
- R12: During and after reset, `req_ready_o` is 1, all three strobes are high, `fl_dq_oe_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 no operation |
| req_addr_i | input | ADDR_W | Byte or sector address |
| req_data_i | input | 8 | Byte to program |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Success, valid with done_o |
| timeout_o | output | 1 | Poll budget exhausted, valid with done_o |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_we_no | output | 1 | Write enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |

## Verification
Each bus cycle takes SETUP_CYC + PULSE_CYC + HOLD_CYC clocks, plus one idle clock, so a request's `done_o` arrives a data-dependent number of cycles after acceptance. The bench therefore waits for the pulse, sampling on falling clock edges, and checks `req_ready_o` on the falling edge one cycle after the request is driven. The flash model counts strobe edges rather than cycles, so each check is exact:
- write order and content;
- stability of address and data between the edges of write-enable;
- the number of poll and verify reads.

A falling-edge monitor measures the setup and strobe widths in whole clocks, and the cycle after `done_o` is checked for the pulse having dropped.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    BC_IDLE,
    BC_SETUP,
    BC_PULSE,
    BC_HOLD
  } bc_state_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WR_WAIT,
    ST_RD,
    ST_RD_WAIT,
    ST_FIN
  } ctl_state_e;

  localparam logic [14:0] UNLK_A1 = 15'h5555;
  localparam logic [14:0] UNLK_A2 = 15'h2AAA;
  localparam logic [7:0]  UNLK_D1 = 8'hAA;
  localparam logic [7:0]  UNLK_D2 = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  ERASED    = 8'hFF;

endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  fop_e              op_i,
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  output logic [2:0]        last_o
);

  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLK_A1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLK_A2);

  always_comb begin
    last_o = (op_i == OP_PROG) ? 3'd3 : 3'd5;
    addr_o = A1;
    data_o = UNLK_D1;
    if (step_i == last_o) begin
      unique case (op_i)
        OP_PROG: begin addr_o = addr_i; data_o = data_i;   end
        OP_SECT: begin addr_o = addr_i; data_o = CMD_SECT; end
        default: begin addr_o = A1;     data_o = CMD_CHIP; end
      endcase
    end else begin
      // unlock pattern repeats with period three
      unique case (step_i)
        3'd1, 3'd4: begin addr_o = A2; data_o = UNLK_D2; end
        3'd2:       begin addr_o = A1; data_o = (op_i == OP_PROG) ? CMD_PROG : CMD_ERASE; end
        default:    begin addr_o = A1; data_o = UNLK_D1; end
      endcase
    end
  end

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_ce_no,
  output logic              fl_we_no,
  output logic              fl_oe_no
);

  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  bc_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [7:0]        rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BC_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        BC_IDLE: if (start_i) begin
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          data_q  <= data_i;
          cnt_q   <= CNT_W'(SETUP_CYC - 1);
          state_q <= BC_SETUP;
        end
        BC_SETUP: if (cnt_q == '0) begin
          cnt_q   <= CNT_W'(PULSE_CYC - 1);
          state_q <= BC_PULSE;
        end else cnt_q <= cnt_q - 1'b1;
        BC_PULSE: if (cnt_q == '0) begin
          rdata_q <= fl_dq_i;  // sampled before the strobe rises
          cnt_q   <= CNT_W'(HOLD_CYC - 1);
          state_q <= BC_HOLD;
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) state_q <= BC_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign done_o     = (state_q == BC_HOLD) && (cnt_q == '0);
  assign rdata_o    = rdata_q;
  assign fl_addr_o  = addr_q;
  assign fl_dq_o    = data_q;
  assign fl_dq_oe_o = (state_q != BC_IDLE) && wr_q;
  assign fl_ce_no   = (state_q == BC_IDLE);
  assign fl_we_no   = !((state_q == BC_PULSE) && wr_q);
  assign fl_oe_no   = !((state_q == BC_PULSE) && !wr_q);

  a_r4_addr_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));

  a_r4_ce_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || !fl_oe_no) |-> !fl_ce_no);

  a_r4_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));

  a_r4_dq_driven_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> fl_dq_oe_o);

endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int HOLD_CYC   = 2,
  parameter int PROG_POLLS = 12,
  parameter int SECT_POLLS = 20,
  parameter int CHIP_POLLS = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  output logic              done_o,
  output logic              ok_o,
  output logic              timeout_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_ce_no,
  output logic              fl_we_no,
  output logic              fl_oe_no
);

  localparam int MAX_PS    = (PROG_POLLS > SECT_POLLS) ? PROG_POLLS : SECT_POLLS;
  localparam int MAX_POLLS = (MAX_PS > CHIP_POLLS) ? MAX_PS : CHIP_POLLS;
  localparam int POLL_W    = $clog2(MAX_POLLS + 1);

  ctl_state_e        state_q;
  fop_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [2:0]        step_q;
  logic [POLL_W-1:0] poll_q;
  logic              prev6_q, have_prev_q, verif_q, vcnt_q, vfail_q, ok_q, tmo_q;

  logic [ADDR_W-1:0] seq_addr;
  logic [7:0]        seq_data, rdata, expect_byte;
  logic [2:0]        last_step;
  logic              bc_done, bc_start, bad;
  logic [POLL_W-1:0] poll_lim_m1;

  flash_seq_table #(.ADDR_W(ADDR_W)) u_table (
    .op_i  (op_q),
    .step_i(step_q),
    .addr_i(addr_q),
    .data_i(data_q),
    .addr_o(seq_addr),
    .data_o(seq_data),
    .last_o(last_step)
  );

  assign bc_start = (state_q == ST_WR) || (state_q == ST_RD);

  flash_bus_cycle #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (bc_start),
    .wr_i      (state_q == ST_WR),
    .addr_i    ((state_q == ST_WR) ? seq_addr : addr_q),
    .data_i    (seq_data),
    .done_o    (bc_done),
    .rdata_o   (rdata),
    .fl_addr_o (fl_addr_o),
    .fl_dq_o   (fl_dq_o),
    .fl_dq_oe_o(fl_dq_oe_o),
    .fl_dq_i   (fl_dq_i),
    .fl_ce_no  (fl_ce_no),
    .fl_we_no  (fl_we_no),
    .fl_oe_no  (fl_oe_no)
  );

  always_comb begin
    unique case (op_q)
      OP_PROG: poll_lim_m1 = POLL_W'(PROG_POLLS - 1);
      OP_SECT: poll_lim_m1 = POLL_W'(SECT_POLLS - 1);
      default: poll_lim_m1 = POLL_W'(CHIP_POLLS - 1);
    endcase
  end

  assign expect_byte = (op_q == OP_PROG) ? data_q : ERASED;
  assign bad         = (rdata != expect_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_NONE;
      addr_q      <= '0;
      data_q      <= '0;
      step_q      <= '0;
      poll_q      <= '0;
      prev6_q     <= 1'b0;
      have_prev_q <= 1'b0;
      verif_q     <= 1'b0;
      vcnt_q      <= 1'b0;
      vfail_q     <= 1'b0;
      ok_q        <= 1'b0;
      tmo_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q        <= fop_e'(req_op_i);
          addr_q      <= req_addr_i;
          data_q      <= req_data_i;
          step_q      <= '0;
          poll_q      <= '0;
          have_prev_q <= 1'b0;
          verif_q     <= 1'b0;
          vcnt_q      <= 1'b0;
          vfail_q     <= 1'b0;
          ok_q        <= 1'b0;
          tmo_q       <= 1'b0;
          state_q     <= (fop_e'(req_op_i) == OP_NONE) ? ST_FIN : ST_WR;
        end
        ST_WR: state_q <= ST_WR_WAIT;
        ST_WR_WAIT: if (bc_done) begin
          if (step_q == last_step) state_q <= ST_RD;
          else begin
            step_q  <= step_q + 3'd1;
            state_q <= ST_WR;
          end
        end
        ST_RD: state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (bc_done) begin
          if (!verif_q) begin
            if (have_prev_q && (rdata[6] == prev6_q)) begin
              verif_q <= 1'b1;
              state_q <= ST_RD;
            end else if (poll_q == poll_lim_m1) begin
              tmo_q   <= 1'b1;
              state_q <= ST_FIN;
            end else begin
              poll_q      <= poll_q + 1'b1;
              prev6_q     <= rdata[6];
              have_prev_q <= 1'b1;
              state_q     <= ST_RD;
            end
          end else if (vcnt_q) begin
            ok_q    <= !(vfail_q || bad);
            state_q <= ST_FIN;
          end else begin
            vfail_q <= bad;
            vcnt_q  <= 1'b1;
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign ok_o        = done_o && ok_q;
  assign timeout_o   = done_o && tmo_q;

  a_r9_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_ok_tmo_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && timeout_o));

  a_r5_no_read_while_writing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_WAIT) |-> fl_oe_no);

endmodule

// File: tb/flash_wr_ctrl_tb.sv
`timescale 1ns/1ps
module flash_wr_ctrl_tb;

  localparam int AW = 18, SU = 2, PW = 3, HD = 2, PP = 12, SP = 20, CP = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          done, ok, tmo;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_o, fl_dq_i;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  flash_wr_ctrl #(
    .ADDR_W(AW), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD),
    .PROG_POLLS(PP), .SECT_POLLS(SP), .CHIP_POLLS(CP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .ok_o(ok), .timeout_o(tmo),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_no(fl_ce_n), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n)
  );

  int tests = 0, fails = 0;

  // flash model
  int wr_cnt = 0, rd_cnt = 0, early_rd = 0, exp_wr = 0, busy_left = 0, busy_cfg = 0;
  int stab_err = 0, strobe_err = 0, tim_err = 0;
  bit bad_mode = 0, prog_mode = 0;
  logic [7:0]    mem_val = 8'hFF;
  logic          tog = 1'b0;
  logic [AW-1:0] wlog_a [8];
  logic [7:0]    wlog_d [8];
  logic [AW-1:0] a_fall;
  logic [7:0]    d_fall;

  always @(negedge fl_we_n) begin
    a_fall = fl_addr;
    d_fall = fl_dq_o;
    if (fl_ce_n || !fl_oe_n || !fl_dq_oe) strobe_err++;
  end

  always @(posedge fl_we_n) begin
    if (fl_addr !== a_fall || fl_dq_o !== d_fall) stab_err++;
    if (wr_cnt < 8) begin
      wlog_a[wr_cnt] = fl_addr;
      wlog_d[wr_cnt] = fl_dq_o;
    end
    wr_cnt++;
    if (wr_cnt == exp_wr) begin
      busy_left = busy_cfg;
      mem_val   = prog_mode ? fl_dq_o : 8'hFF;
    end
  end

  always @(negedge fl_oe_n) begin
    rd_cnt++;
    if (wr_cnt < exp_wr) early_rd++;
    if (fl_ce_n || !fl_we_n) strobe_err++;
  end

  always @(posedge fl_oe_n) begin
    if (busy_left > 0) begin
      tog = ~tog;
      busy_left--;
    end
  end

  assign fl_dq_i = (busy_left > 0) ? {~mem_val[7], tog, 6'b0}
                                   : (bad_mode ? ~mem_val : mem_val);

  // strobe width monitor, sampled mid-cycle
  int  ce_run = 0, we_run = 0;
  bit  prev_we = 1'b1;
  always @(negedge clk) begin
    if (!fl_ce_n) ce_run++; else ce_run = 0;
    if (!fl_we_n) begin
      if (prev_we && ce_run != SU + 1) tim_err++;
      we_run++;
    end else begin
      if (!prev_we && we_run != PW) tim_err++;
      we_run = 0;
    end
    prev_we = fl_we_n;
  end

  task automatic chk(input bit c, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic model_arm(input int ew, input int busy, input bit bad, input bit prog);
    wr_cnt = 0; rd_cnt = 0; early_rd = 0; exp_wr = ew; busy_cfg = busy;
    busy_left = 0; bad_mode = bad; prog_mode = prog; tog = 1'b0;
    stab_err = 0; strobe_err = 0; tim_err = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input int ew, input int busy, input bit bad,
                       output logic r_ok, output logic r_tmo, output int ready_hi);
    @(negedge clk);
    model_arm(ew, busy, bad, op == 2'd0);
    chk(req_ready === 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R9 ready low after accept", req_ready, 0);
    ready_hi = 0;
    while (done !== 1'b1) begin
      @(negedge clk);
      if (req_ready && !done) ready_hi++;
    end
    r_ok = ok; r_tmo = tmo;
    @(negedge clk);
    chk(done === 1'b0 && ok === 1'b0 && tmo === 1'b0, "R10 done single pulse", {done, ok, tmo}, 0);
    chk(req_ready === 1'b1, "R9 ready after done", req_ready, 1);
  endtask

  task automatic chk_log(input string r, input int n, input logic [AW-1:0] ea [6], input logic [7:0] ed [6]);
    chk(wr_cnt == n, {r, " write count"}, wr_cnt, n);
    for (int i = 0; i < n; i++) begin
      chk(wlog_a[i] === ea[i], {r, " write address"}, wlog_a[i], ea[i]);
      chk(wlog_d[i] === ed[i], {r, " write data"}, wlog_d[i], ed[i]);
    end
  endtask

  task automatic chk_bus(input string tag);
    chk(early_rd == 0, {tag, " R5 read before final write"}, early_rd, 0);
    chk(stab_err == 0 && strobe_err == 0, {tag, " R4 strobe/stability"}, stab_err + strobe_err, 0);
    chk(tim_err == 0, {tag, " R4 setup/pulse width"}, tim_err, 0);
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1 && done === 1'b0, "R12 ready/done at reset", {req_ready, done}, 2'b10);
    chk(fl_ce_n === 1'b1 && fl_we_n === 1'b1 && fl_oe_n === 1'b1, "R12 strobes high",
        {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(fl_dq_oe === 1'b0, "R12 data bus released", fl_dq_oe, 0);
  endtask

  task automatic t_program();
    logic r_ok, r_tmo; int rh;
    logic [AW-1:0] ea [6] = '{18'h05555, 18'h02AAA, 18'h05555, 18'h21234, 18'h0, 18'h0};
    logic [7:0]    ed [6] = '{8'hAA, 8'h55, 8'hA0, 8'h5A, 8'h00, 8'h00};
    issue(2'd0, 18'h21234, 8'h5A, 4, 5, 0, r_ok, r_tmo, rh);
    chk_log("R1 program", 4, ea, ed);
    chk(r_ok === 1'b1 && r_tmo === 1'b0, "R7 program success", {r_ok, r_tmo}, 2'b10);
    chk(rd_cnt == 9, "R6 completion read count", rd_cnt, 9);
    chk(rh == 0, "R9 ready stayed low", rh, 0);
    chk_bus("program");
  endtask

  task automatic t_sector();
    logic r_ok, r_tmo; int rh;
    logic [AW-1:0] ea [6] = '{18'h05555, 18'h02AAA, 18'h05555, 18'h05555, 18'h02AAA, 18'h37000};
    logic [7:0]    ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    issue(2'd1, 18'h37000, 8'h00, 6, 3, 0, r_ok, r_tmo, rh);
    chk_log("R2 sector erase", 6, ea, ed);
    chk(r_ok === 1'b1 && r_tmo === 1'b0, "R7 sector erase success", {r_ok, r_tmo}, 2'b10);
    chk(rd_cnt == 7, "R6 sector read count", rd_cnt, 7);
    chk_bus("sector");
  endtask

  task automatic t_chip();
    logic r_ok, r_tmo; int rh;
    logic [AW-1:0] ea [6] = '{18'h05555, 18'h02AAA, 18'h05555, 18'h05555, 18'h02AAA, 18'h05555};
    logic [7:0]    ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    issue(2'd2, 18'h00100, 8'h00, 6, 2, 0, r_ok, r_tmo, rh);
    chk_log("R3 chip erase", 6, ea, ed);
    chk(r_ok === 1'b1, "R7 chip erase success", r_ok, 1);
    // busy bit 6 and erased bit 6 coincide: completion on the first data read
    chk(rd_cnt == 5, "R6 chip read count", rd_cnt, 5);
    chk_bus("chip");
  endtask

  task automatic t_verify_fail();
    logic r_ok, r_tmo; int rh;
    issue(2'd0, 18'h00042, 8'h5A, 4, 2, 1, r_ok, r_tmo, rh);
    chk(r_ok === 1'b0 && r_tmo === 1'b0, "R7 mismatch reports failure", {r_ok, r_tmo}, 2'b00);
    chk(rd_cnt == 6, "R7 two verify reads", rd_cnt, 6);
  endtask

  task automatic t_timeout();
    logic r_ok, r_tmo; int rh;
    issue(2'd0, 18'h00010, 8'h11, 4, 1000, 0, r_ok, r_tmo, rh);
    chk(r_tmo === 1'b1 && r_ok === 1'b0, "R8 program timeout", {r_ok, r_tmo}, 2'b01);
    chk(rd_cnt == PP, "R8 program poll budget", rd_cnt, PP);
    issue(2'd1, 18'h01000, 8'h00, 6, 1000, 0, r_ok, r_tmo, rh);
    chk(r_tmo === 1'b1 && r_ok === 1'b0, "R8 sector timeout", {r_ok, r_tmo}, 2'b01);
    chk(rd_cnt == SP, "R8 sector poll budget", rd_cnt, SP);
  endtask

  task automatic t_busy_ignore();
    int lo = 0;
    @(negedge clk);
    model_arm(4, 2, 0, 1);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 18'h00777; req_data = 8'hC3;
    @(negedge clk);
    req_op = 2'd2; req_addr = 18'h3FFFF;
    for (int i = 0; i < 30; i++) begin
      if (req_ready === 1'b0) lo++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(lo == 30, "R9 ready low while busy", lo, 30);
    while (done !== 1'b1) @(negedge clk);
    chk(ok === 1'b1, "R9 first request completes", ok, 1);
    @(negedge clk);
    chk(wr_cnt == 4 && wlog_a[3] === 18'h00777 && wlog_d[3] === 8'hC3,
        "R9 busy request ignored", {wr_cnt[7:0], wlog_d[3]}, {8'd4, 8'hC3});
  endtask

  task automatic t_bad_op();
    logic r_ok, r_tmo; int rh;
    issue(2'd3, 18'h00001, 8'h00, 0, 0, 0, r_ok, r_tmo, rh);
    chk(r_ok === 1'b0 && r_tmo === 1'b0, "R11 no-op result", {r_ok, r_tmo}, 0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R11 no bus activity", wr_cnt + rd_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_sector();
    t_chip();
    t_verify_fail();
    t_timeout();
    t_busy_ignore();
    t_bad_op();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule